// File: doc/BRIEF.md
# Prescaled Dual Timer with Watchdog

This block holds two independent down-counting timers and a watchdog counter, all paced by one shared prescaler. The prescaler counts down on every clock. Each time it reaches zero it issues a one-cycle tick and then restarts from its own reload value. An enabled timer moves one step only on a tick.

Each timer can be set to one of two modes. In auto-reload mode it restarts from its reload value after it reaches zero. In stop mode it halts at zero. In both modes the timer raises a one-cycle interrupt pulse when it underflows. A self-clearing load strobe in the control word copies the reload value into the counter immediately.

The watchdog also counts down on ticks. When it reaches zero, a sticky expiry output is set. Software rearms it by writing a new count. All state is reached through a simple 32-bit word-addressed write port and a combinational read port.

Top module: `tick_timer_unit`

## Requirements
- R1: While reset is low, every counter, reload and control register reads 0, except the watchdog count, which reads 0xFFFFFF. `timer_irq` and `wdog_expired` are 0.
- R2: The prescaler count (byte offset 0x20) falls by one every clock. In a cycle where it is 0, a tick occurs and the next value is the prescaler reload (offset 0x24). A write to 0x20 sets the count directly.
- R3: A timer steps down by one only on a tick and only while its enable bit (control bit 0) is 1. While enable is 0, the count holds.
- R4: With control bit 1 set (auto-reload), a tick that finds the count at 0 loads the reload value.
- R5: With control bit 1 clear (stop mode), a tick that finds the count at 0 leaves it at 0 and clears the enable bit.
- R6: The underflow of R4 or R5 drives that timer's `timer_irq` bit high for exactly the following cycle. Bit 0 belongs to timer 1 and bit 1 to timer 2.
- R7: A control write with bit 2 set copies the reload value into the count. Bit 2 always reads back 0. A control write with bit 2 clear leaves the count unchanged.
- R8: The watchdog count (offset 0x0C) steps down on ticks and holds at 0. `wdog_expired` rises the cycle after the count is found at 0 and stays high. A write to 0x0C loads the count and clears `wdog_expired`.
- R9: The word offsets are as follows. Timer 1 uses 0x00 for the count, 0x04 for reload and 0x08 for control. Timer 2 uses 0x10, 0x14 and 0x18 for the same registers. The watchdog is at 0x0C, the prescaler count at 0x20 and the prescaler reload at 0x24. Counts are 24 bits wide, and upper write bits are dropped. Unmapped offsets read 0 and ignore writes.
- R10: Activity on one timer never changes the other timer's count or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| timer_irq | output | 2 | Underflow pulse per timer |
| wdog_expired | output | 1 | Sticky watchdog expiry flag |

## Verification
The bench aligns the prescaler phase and then checks that a timer steps on the exact tick edge. A design that counted on every clock, or that was off by one in the tick period, would show the wrong count at those edges. A scoreboard predicts the exact cycle of every interrupt pulse, so an extra pulse, a missing pulse or a late pulse is caught, including a stop-mode timer that keeps firing at zero.

The bench also covers the corner cases of the load strobe:
- bit 2 written as 0 must not load the count;
- bit 2 must never read back as 1.

For the watchdog, the bench checks the exact cycle in which expiry rises and that the flag stays set until a rearm write clears it. Unmapped offsets and data above 24 bits are also probed, so aliased decoding or writes that are not masked would show up.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Byte offsets inside the register window
  localparam int OFS_CNT    = 0;
  localparam int OFS_RLD    = 4;
  localparam int OFS_CTL    = 8;
  localparam int CH_STRIDE  = 16;
  localparam int OFS_WDOG   = 12;
  localparam int OFS_PCNT   = 32;
  localparam int OFS_PRLD   = 36;

  // Control bits [1:0]; bit 2 is a write-only load strobe
  typedef struct packed {
    logic reload_mode;
    logic enable;
  } tmr_mode_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_cnt,
  input  logic         load_rld,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, rld_q;

  function automatic logic [W-1:0] presc_next(input logic [W-1:0] c, input logic [W-1:0] r);
    return (c == '0) ? r : c - 1'b1;
  endfunction

  assign tick_o = (cnt_q == '0);
  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rld_q <= '0;
    end else begin
      if (load_rld) rld_q <= wdata;
      if (load_cnt) cnt_q <= wdata;
      else          cnt_q <= presc_next(cnt_q, rld_q);
    end
  end

  // R2
  presc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_cnt && !tick_o) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R2
  presc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_cnt && tick_o) |=> cnt_q == $past(rld_q));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_cnt,
  input  logic         wr_rld,
  input  logic         wr_ctl,
  input  logic         load_strobe,
  input  tmr_mode_t    mode_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] rld_o,
  output tmr_mode_t    mode_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q, rld_q;
  tmr_mode_t    mode_q;
  logic         irq_q;
  logic         step_evt, uflow_evt, strobe_evt;

  function automatic logic [W-1:0] count_next(input logic [W-1:0] c, input logic [W-1:0] r,
                                              input logic rl);
    if (c == '0) return rl ? r : '0;
    return c - 1'b1;
  endfunction

  assign step_evt   = tick_i && mode_q.enable;
  assign uflow_evt  = step_evt && (cnt_q == '0);
  assign strobe_evt = wr_ctl && load_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rld_q  <= '0;
      mode_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= uflow_evt;
      if (wr_cnt)          cnt_q <= wdata;
      else if (strobe_evt) cnt_q <= rld_q;
      else if (step_evt)   cnt_q <= count_next(cnt_q, rld_q, mode_q.reload_mode);
      if (wr_rld) rld_q <= wdata;
      if (wr_ctl) mode_q <= mode_wr;
      else if (uflow_evt && !mode_q.reload_mode) mode_q.enable <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign rld_o  = rld_q;
  assign mode_o = mode_q;
  assign irq_o  = irq_q;

  // R3
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q.enable && !wr_cnt && !strobe_evt) |=> $stable(cnt_q));
  // R4
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_evt && mode_q.reload_mode && !wr_cnt && !strobe_evt) |=> cnt_q == $past(rld_q));
  // R5
  stop_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uflow_evt && !mode_q.reload_mode && !wr_ctl) |=> !mode_q.enable);
  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($past(cnt_q) == '0) && $past(step_evt));
endmodule

// File: rtl/tmr_watchdog.sv
module tmr_watchdog #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_o,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;
  logic         exp_q;
  logic         at_zero;

  function automatic logic [W-1:0] wd_next(input logic [W-1:0] c, input logic t);
    return (t && c != '0) ? c - 1'b1 : c;
  endfunction

  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      exp_q <= 1'b0;
    end else if (wr_i) begin
      cnt_q <= wdata;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= wd_next(cnt_q, tick_i);
      if (at_zero) exp_q <= 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign expired_o = exp_q;

  // R8
  wd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !wr_i) |=> expired_o);
  // R8
  wd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (at_zero && !wr_i) |=> cnt_q == '0);
  // R8
  wd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired_o) |-> $past(cnt_q) == '0);
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import tmr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 24,
  parameter int PRESC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        timer_irq,
  output logic              wdog_expired
);
  localparam int NUM_CH = 2;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic              presc_tick;
  logic [PRESC_W-1:0] presc_cnt, presc_rld;
  logic [CNT_W-1:0]  ch_cnt [NUM_CH];
  logic [CNT_W-1:0]  ch_rld [NUM_CH];
  tmr_mode_t         ch_mode[NUM_CH];
  logic [CNT_W-1:0]  wd_cnt;
  tmr_mode_t         wr_mode;
  logic              unused_wdata;

  assign wr_mode      = tmr_mode_t'(bus_wdata[1:0]);
  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

  tmr_prescaler #(.W(PRESC_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_cnt (bus_we && hit(bus_addr, OFS_PCNT)),
    .load_rld (bus_we && hit(bus_addr, OFS_PRLD)),
    .wdata    (bus_wdata[PRESC_W-1:0]),
    .cnt_o    (presc_cnt),
    .rld_o    (presc_rld),
    .tick_o   (presc_tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = g * CH_STRIDE;
    tmr_channel #(.W(CNT_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (presc_tick),
      .wr_cnt      (bus_we && hit(bus_addr, BASE + OFS_CNT)),
      .wr_rld      (bus_we && hit(bus_addr, BASE + OFS_RLD)),
      .wr_ctl      (bus_we && hit(bus_addr, BASE + OFS_CTL)),
      .load_strobe (bus_wdata[2]),
      .mode_wr     (wr_mode),
      .wdata       (bus_wdata[CNT_W-1:0]),
      .cnt_o       (ch_cnt[g]),
      .rld_o       (ch_rld[g]),
      .mode_o      (ch_mode[g]),
      .irq_o       (timer_irq[g])
    );
  end

  tmr_watchdog #(.W(CNT_W)) u_wd (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (presc_tick),
    .wr_i      (bus_we && hit(bus_addr, OFS_WDOG)),
    .wdata     (bus_wdata[CNT_W-1:0]),
    .cnt_o     (wd_cnt),
    .expired_o (wdog_expired)
  );

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit(bus_addr, i * CH_STRIDE + OFS_CNT)) bus_rdata = DATA_W'(ch_cnt[i]);
      if (hit(bus_addr, i * CH_STRIDE + OFS_RLD)) bus_rdata = DATA_W'(ch_rld[i]);
      if (hit(bus_addr, i * CH_STRIDE + OFS_CTL)) bus_rdata = DATA_W'(ch_mode[i]);
    end
    if (hit(bus_addr, OFS_WDOG)) bus_rdata = DATA_W'(wd_cnt);
    if (hit(bus_addr, OFS_PCNT)) bus_rdata = DATA_W'(presc_cnt);
    if (hit(bus_addr, OFS_PRLD)) bus_rdata = DATA_W'(presc_rld);
  end

  // R6
  irq_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> timer_irq == 2'b00);
endmodule

// File: tb/tb_tick_timer_unit.sv
module tb_tick_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  timer_irq;
  logic        wdog_expired;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int q1[$];
  int q2[$];

  tick_timer_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_irq(timer_irq),
    .wdog_expired(wdog_expired)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the predicted pulse cycle for each timer
  always @(negedge clk) begin
    if (rst_n) begin
      if (timer_irq[0]) begin
        if (q1.size() == 0) check("R6 unexpected timer1 pulse", 32'(cyc), 32'hFFFFFFFF);
        else check("R6 timer1 pulse cycle", 32'(cyc), 32'(q1.pop_front()));
      end
      if (timer_irq[1]) begin
        if (q2.size() == 0) check("R10 unexpected timer2 pulse", 32'(cyc), 32'hFFFFFFFF);
        else check("R6 timer2 pulse cycle", 32'(cyc), 32'(q2.pop_front()));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1-all: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e0;
    step(3);
    // R1 reset state
    rd(8'h00, 0, "R1 cnt1"); rd(8'h08, 0, "R1 ctl1"); rd(8'h14, 0, "R1 rld2");
    rd(8'h0C, 32'hFFFFFF, "R1 wdog"); rd(8'h20, 0, "R1 presc cnt"); rd(8'h24, 0, "R1 presc rld");
    check("R1 irq", 32'(timer_irq), 0); check("R1 expired", 32'(wdog_expired), 0);
    rst_n = 1'b1;
    step(2);

    // R2 prescaler sequence
    wr(8'h24, 3); wr(8'h20, 3);
    rd(8'h20, 3, "R2 presc load"); step(1);
    rd(8'h20, 2, "R2 presc dec"); step(1);
    rd(8'h20, 1, "R2 presc dec"); step(1);
    rd(8'h20, 0, "R2 presc zero"); step(1);
    rd(8'h20, 3, "R2 presc wrap");

    // R3 hold while disabled, then step on ticks only
    wr(8'h00, 5); step(10);
    rd(8'h00, 5, "R3 hold disabled");
    wr(8'h20, 3); wr(8'h08, 1);
    rd(8'h00, 5, "R3 no early step"); rd(8'h08, 1, "R3 ctl readback");
    step(2); rd(8'h00, 5, "R3 before tick");
    step(1); rd(8'h00, 4, "R3 first tick");
    step(3); rd(8'h00, 4, "R3 between ticks");
    step(1); rd(8'h00, 3, "R3 second tick");
    wr(8'h08, 0); wr(8'h24, 0); wr(8'h20, 0);

    // R4 / R6 auto-reload with tick every cycle
    wr(8'h04, 2); wr(8'h08, 7);
    e0 = cyc; q1.push_back(e0 + 3); q1.push_back(e0 + 6);
    rd(8'h08, 3, "R7 strobe reads 0"); rd(8'h00, 2, "R7 strobe loads");
    step(3); rd(8'h00, 2, "R4 reloaded");
    step(3);
    wr(8'h08, 0);
    step(4); rd(8'h00, 1, "R3 held after disable");

    // R5 stop mode on timer 2
    wr(8'h14, 7); wr(8'h10, 1); wr(8'h18, 1);
    e0 = cyc; q2.push_back(e0 + 2);
    rd(8'h10, 1, "R5 start"); step(1);
    rd(8'h10, 0, "R5 at zero"); step(1);
    rd(8'h18, 0, "R5 enable cleared"); rd(8'h10, 0, "R5 stays zero");
    step(5); rd(8'h10, 0, "R5 still zero");
    rd(8'h00, 1, "R10 timer1 untouched");

    // R7 strobe bit clear has no effect
    wr(8'h18, 0); rd(8'h10, 0, "R7 no load on bit2=0");
    wr(8'h18, 4); rd(8'h10, 7, "R7 load on bit2=1"); rd(8'h18, 0, "R7 ctl after strobe");
    step(3); rd(8'h10, 7, "R7 held disabled");

    // R8 watchdog
    wr(8'h0C, 3);
    rd(8'h0C, 3, "R8 wdog load"); check("R8 not expired", 32'(wdog_expired), 0);
    step(3); rd(8'h0C, 0, "R8 wdog zero"); check("R8 expiry timing", 32'(wdog_expired), 0);
    step(1); check("R8 expired", 32'(wdog_expired), 1);
    step(5); check("R8 sticky", 32'(wdog_expired), 1); rd(8'h0C, 0, "R8 holds zero");
    wr(8'h0C, 100);
    check("R8 rearm clears", 32'(wdog_expired), 0); rd(8'h0C, 100, "R8 rearm value");
    step(1); rd(8'h0C, 99, "R8 counting");

    // R9 map
    rd(8'h1C, 0, "R9 unmapped 1C"); rd(8'h28, 0, "R9 unmapped 28");
    wr(8'h1C, 32'hDEAD);
    rd(8'h04, 2, "R9 rld1 intact"); rd(8'h14, 7, "R9 rld2 intact"); rd(8'h1C, 0, "R9 1C still 0");
    wr(8'h04, 32'hFF123456); rd(8'h04, 32'h00123456, "R9 24-bit mask");

    step(3);
    check("R6 all predicted pulses seen", 32'(q1.size() + q2.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule